// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block sits on the processor side of an interrupt path. It decides at each instruction boundary whether to take an external interrupt, and then runs the entry sequence. There are two request lines. The non-maskable one is always honoured. The maskable one is gated by a software interrupt-enable flag and is simply left waiting while that flag is clear.

For a maskable request the block pulses an acknowledge and captures a vector byte from the interrupt controller. A non-maskable entry uses a fixed internal vector instead. The block then pushes the flag word, the code segment and the program counter onto the stack through a valid/ready memory port, and clears the enable and trap flags. It reads the handler's program counter and code segment from the vector table and presents them together with the updated stack pointer.

The surrounding core supplies the current flag word, segment, program counter and stack pointer. It loads the new values when the completion pulse appears.

Top module: `intr_entry_seq`

## Requirements
- R1: A non-maskable request present on a boundary cycle is taken whatever the enable flag holds. It uses vector 2 and raises no acknowledge.
- R2: A maskable request is taken only when the enable flag is 1 at the boundary. While the flag is 0, a held request stays waiting and is taken at the first boundary after the flag is set.
- R3: A pulse on `ie_set` sets the enable flag and a pulse on `ie_clr` clears it, with clear winning when both are high. A pulse on `tf_set` sets the trap flag. Each change is visible on the flag outputs one cycle later.
- R4: Requests are sampled only on cycles where `insn_end` is high. A request held without a boundary strobe starts nothing.
- R5: A maskable entry raises `int_ack` for exactly one cycle and uses the `vec_in` byte present during that cycle as vector n.
- R6: The entry performs three writes in this order. The flag word goes to SP-2, with bit 9 replaced by the old enable flag and bit 8 replaced by the old trap flag. The code segment goes to SP-4 and the program counter to SP-6. `new_sp` then reads SP-6.
- R7: Acceptance clears both the enable flag and the trap flag.
- R8: After the pushes, the block reads the new program counter from address 4n and the new code segment from address 4n+2 (`mem_we` low). These values appear on `new_pc` and `new_cs`.
- R9: When both requests are present at the same boundary, the non-maskable one is taken and no acknowledge occurs.
- R10: Each memory transfer keeps `mem_valid`, `mem_we`, `mem_addr` and `mem_wdata` steady until a cycle with `mem_ready` high, and only then advances.
- R11: `busy` is high from the cycle after acceptance until the last table read completes. `entry_done` pulses for one cycle as `busy` falls. No request is sampled while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_req | input | 1 | Non-maskable request level |
| irq_req | input | 1 | Maskable request level |
| insn_end | input | 1 | Instruction-boundary strobe |
| ie_set | input | 1 | Set enable flag command |
| ie_clr | input | 1 | Clear enable flag command |
| tf_set | input | 1 | Set trap flag command |
| flags_in | input | 16 | Current flag word (bits 8, 9 replaced) |
| cs_in | input | 16 | Current code segment |
| pc_in | input | 16 | Current program counter |
| sp_in | input | 16 | Current stack pointer |
| vec_in | input | 8 | Vector byte from the controller |
| int_ack | output | 1 | Acknowledge pulse |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_ready | input | 1 | Memory transfer complete |
| mem_rdata | input | 16 | Memory read data |
| busy | output | 1 | Entry in progress |
| ie_flag | output | 1 | Interrupt-enable flag |
| tf_flag | output | 1 | Trap flag |
| new_pc | output | 16 | Handler program counter |
| new_cs | output | 16 | Handler code segment |
| new_sp | output | 16 | Stack pointer after pushes |
| entry_done | output | 1 | One-cycle completion pulse |

## Verification
A wrong sequencer state shows up directly on the memory port. A skipped or repeated step changes the number of writes or their addresses at the next transfer. A stuck state keeps `busy` high, so the measured busy length no longer matches 1+L+4(L+2) cycles (plus one for the acknowledge), where L is the memory latency. A corrupted vector or saved register shows up within that same entry as a wrong table address, push value or `new_pc`/`new_cs`. A flag that is not cleared shows on `ie_flag`/`tf_flag` one cycle after acceptance. Sweeping vectors and latencies exposes all of these within a single entry.

// File: rtl/intr_pkg.sv
package intr_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_ACK,
        S_PUSH_FL,
        S_PUSH_CS,
        S_PUSH_PC,
        S_RD_PC,
        S_RD_CS
    } seq_st_t;
endpackage

// File: rtl/intr_arb.sv
module intr_arb (
    input  logic nmi_req,
    input  logic irq_req,
    input  logic ie,
    input  logic boundary,
    input  logic busy,
    output logic take,
    output logic take_nmi
);
    logic open_window;

    always_comb begin
        open_window = boundary && !busy;
        take_nmi    = open_window && nmi_req;
        take        = take_nmi || (open_window && irq_req && ie);
    end
endmodule

// File: rtl/intr_memreq.sv
module intr_memreq
    import intr_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int VW = 8
) (
    input  seq_st_t          st,
    input  logic [AW-1:0]    sp,
    input  logic [DW-1:0]    fl,
    input  logic [DW-1:0]    cs,
    input  logic [DW-1:0]    pc,
    input  logic [VW-1:0]    vec,
    output logic             valid,
    output logic             we,
    output logic [AW-1:0]    addr,
    output logic [DW-1:0]    wdata
);
    localparam int PADW = AW - VW - 2;
    localparam logic [AW-1:0] WSTEP = AW'(2);

    logic [AW-1:0] tbl_base;

    always_comb begin
        tbl_base = {{PADW{1'b0}}, vec, 2'b00};
        valid    = 1'b1;
        we       = 1'b1;
        addr     = sp - WSTEP;
        wdata    = '0;
        case (st)
            S_PUSH_FL: wdata = fl;
            S_PUSH_CS: wdata = cs;
            S_PUSH_PC: wdata = pc;
            S_RD_PC: begin
                we   = 1'b0;
                addr = tbl_base;
            end
            S_RD_CS: begin
                we   = 1'b0;
                addr = tbl_base | WSTEP;
            end
            default: begin
                valid = 1'b0;
                we    = 1'b0;
                addr  = '0;
            end
        endcase
    end
endmodule

// File: rtl/intr_entry_seq.sv
module intr_entry_seq
    import intr_pkg::*;
#(
    parameter int AW       = 16,
    parameter int DW       = 16,
    parameter int VW       = 8,
    parameter int NMI_VEC  = 2,
    parameter int IE_BIT   = 9,
    parameter int TF_BIT   = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          nmi_req,
    input  logic          irq_req,
    input  logic          insn_end,
    input  logic          ie_set,
    input  logic          ie_clr,
    input  logic          tf_set,
    input  logic [DW-1:0] flags_in,
    input  logic [DW-1:0] cs_in,
    input  logic [DW-1:0] pc_in,
    input  logic [AW-1:0] sp_in,
    input  logic [VW-1:0] vec_in,
    output logic          int_ack,
    output logic          mem_valid,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ready,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          ie_flag,
    output logic          tf_flag,
    output logic [DW-1:0] new_pc,
    output logic [DW-1:0] new_cs,
    output logic [AW-1:0] new_sp,
    output logic          entry_done
);
    localparam logic [AW-1:0] WSTEP    = AW'(2);
    localparam logic [VW-1:0] NMI_VECV = VW'(NMI_VEC);

    typedef struct packed {
        seq_st_t       st;
        logic          ie;
        logic          tf;
        logic [AW-1:0] sp;
        logic [DW-1:0] fl;
        logic [DW-1:0] cs;
        logic [DW-1:0] pc;
        logic [VW-1:0] vec;
        logic [DW-1:0] npc;
        logic [DW-1:0] ncs;
        logic          done;
    } seq_state_t;

    seq_state_t q, d;
    logic       take_w, take_nmi_w;
    logic [DW-1:0] fl_snap;

    intr_arb u_arb (
        .nmi_req  (nmi_req),
        .irq_req  (irq_req),
        .ie       (q.ie),
        .boundary (insn_end),
        .busy     (busy),
        .take     (take_w),
        .take_nmi (take_nmi_w)
    );

    intr_memreq #(.AW(AW), .DW(DW), .VW(VW)) u_memreq (
        .st    (q.st),
        .sp    (q.sp),
        .fl    (q.fl),
        .cs    (q.cs),
        .pc    (q.pc),
        .vec   (q.vec),
        .valid (mem_valid),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        fl_snap         = flags_in;
        fl_snap[IE_BIT] = q.ie;
        fl_snap[TF_BIT] = q.tf;
        if (ie_set) d.ie = 1'b1;
        if (ie_clr) d.ie = 1'b0;
        if (tf_set) d.tf = 1'b1;
        case (q.st)
            S_IDLE: begin
                if (take_w) begin
                    d.fl = fl_snap;
                    d.cs = cs_in;
                    d.pc = pc_in;
                    d.sp = sp_in;
                    d.ie = 1'b0;
                    d.tf = 1'b0;
                    if (take_nmi_w) begin
                        d.vec = NMI_VECV;
                        d.st  = S_PUSH_FL;
                    end else begin
                        d.st  = S_ACK;
                    end
                end
            end
            S_ACK: begin
                d.vec = vec_in;
                d.st  = S_PUSH_FL;
            end
            S_PUSH_FL: if (mem_ready) begin
                d.sp = q.sp - WSTEP;
                d.st = S_PUSH_CS;
            end
            S_PUSH_CS: if (mem_ready) begin
                d.sp = q.sp - WSTEP;
                d.st = S_PUSH_PC;
            end
            S_PUSH_PC: if (mem_ready) begin
                d.sp = q.sp - WSTEP;
                d.st = S_RD_PC;
            end
            S_RD_PC: if (mem_ready) begin
                d.npc = mem_rdata;
                d.st  = S_RD_CS;
            end
            S_RD_CS: if (mem_ready) begin
                d.ncs  = mem_rdata;
                d.done = 1'b1;
                d.st   = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign busy       = (q.st != S_IDLE);
    assign int_ack    = (q.st == S_ACK);
    assign ie_flag    = q.ie;
    assign tf_flag    = q.tf;
    assign new_pc     = q.npc;
    assign new_cs     = q.ncs;
    assign new_sp     = q.sp;
    assign entry_done = q.done;
endmodule

// File: rtl/intr_entry_chk.sv
module intr_entry_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          insn_end,
    input logic          nmi_req,
    input logic          busy,
    input logic          ie_flag,
    input logic          tf_flag,
    input logic          int_ack,
    input logic          mem_valid,
    input logic          mem_ready,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          entry_done
);
    // R4
    start_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(insn_end));

    // R2
    masked_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && !$past(nmi_req)) |-> $past(ie_flag));

    // R7
    flags_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (!ie_flag && !tf_flag));

    // R1
    nmi_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && $past(nmi_req)) |-> !int_ack);

    // R5
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack |=> !int_ack);

    // R10
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)));

    // R11
    valid_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid || int_ack) |-> busy);

    // R11
    done_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> entry_done);
endmodule

bind intr_entry_seq intr_entry_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .insn_end   (insn_end),
    .nmi_req    (nmi_req),
    .busy       (busy),
    .ie_flag    (ie_flag),
    .tf_flag    (tf_flag),
    .int_ack    (int_ack),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .entry_done (entry_done)
);

// File: tb/test_intr_entry_seq.sv
module test_intr_entry_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nmi_req = 0, irq_req = 0, insn_end = 0;
    logic        ie_set = 0, ie_clr = 0, tf_set = 0;
    logic [15:0] flags_in = 0, cs_in = 0, pc_in = 0, sp_in = 0;
    logic [7:0]  vec_in = 0;
    logic        int_ack, mem_valid, mem_we, mem_ready = 0;
    logic [15:0] mem_addr, mem_wdata, mem_rdata = 0;
    logic        busy, ie_flag, tf_flag, entry_done;
    logic [15:0] new_pc, new_cs, new_sp;

    int total = 0, bad = 0;
    int lat = 0, wcnt = 0;
    int wr_cnt = 0, rd_cnt = 0, ack_cnt = 0, done_cnt = 0, busy_cnt = 0;
    logic [15:0] wr_addr [0:1023];
    logic [15:0] wr_data [0:1023];

    always #4 clk = ~clk;

    intr_entry_seq i_intr_entry_seq (.*);

    function automatic logic [15:0] tbl(input logic [15:0] a);
        return a * 16'd7 + 16'h1357;
    endfunction

    // memory model and event counters, all at the falling edge
    always @(negedge clk) begin
        if (int_ack) ack_cnt <= ack_cnt + 1;
        if (entry_done) done_cnt <= done_cnt + 1;
        if (busy) busy_cnt <= busy_cnt + 1;
        if (mem_ready) begin
            mem_ready <= 1'b0;
        end else if (mem_valid) begin
            if (wcnt >= lat) begin
                mem_ready <= 1'b1;
                wcnt <= 0;
                if (mem_we) begin
                    wr_addr[wr_cnt[9:0]] <= mem_addr;
                    wr_data[wr_cnt[9:0]] <= mem_wdata;
                    wr_cnt <= wr_cnt + 1;
                end else begin
                    mem_rdata <= tbl(mem_addr);
                    rd_cnt <= rd_cnt + 1;
                end
            end else begin
                wcnt <= wcnt + 1;
            end
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_done(input int d0);
        for (int i = 0; i < 300 && done_cnt == d0; i++) tick();
    endtask

    task automatic entry(input logic nmi, input logic irq, input logic [7:0] n,
                         input int lt, input logic want_ie, input logic want_tf,
                         input logic [15:0] sp);
        int w0, a0, d0, b0;
        logic [7:0] ev;
        logic [15:0] efl;
        ie_set = want_ie; ie_clr = !want_ie; tf_set = want_tf;
        tick();
        ie_set = 0; ie_clr = 0; tf_set = 0;
        tick();
        chk("R3 enable flag after command", ie_flag, want_ie);
        chk("R3 trap flag after command", tf_flag, want_tf);
        lat = lt; vec_in = n;
        flags_in = 16'hA3C5 ^ {8'h00, n};
        cs_in = 16'h4000 + 16'(n); pc_in = 16'h6000 - 16'(n); sp_in = sp;
        w0 = wr_cnt; a0 = ack_cnt; d0 = done_cnt; b0 = busy_cnt;
        nmi_req = nmi; irq_req = irq; insn_end = 1;
        tick();
        insn_end = 0; nmi_req = 0; irq_req = 0;
        vec_in = nmi ? n : ~n;
        if (!nmi) begin
            vec_in = n;
            tick();
            vec_in = ~n;
        end
        wait_done(d0);
        tick();
        ev = nmi ? 8'd2 : n;
        efl = (flags_in & 16'hFCFF) | (16'(want_ie) << 9) | (16'(want_tf) << 8);
        chk("R6 write count", wr_cnt - w0, 3);
        chk("R6 flags addr", wr_addr[w0[9:0]], sp - 16'd2);
        chk("R6 flags data", wr_data[w0[9:0]], efl);
        chk("R6 cs addr", wr_addr[(w0 + 1) % 1024], sp - 16'd4);
        chk("R6 cs data", wr_data[(w0 + 1) % 1024], cs_in);
        chk("R6 pc addr", wr_addr[(w0 + 2) % 1024], sp - 16'd6);
        chk("R6 pc data", wr_data[(w0 + 2) % 1024], pc_in);
        chk("R6 new sp", new_sp, sp - 16'd6);
        chk(nmi ? "R9 R1 no ack" : "R5 one ack", ack_cnt - a0, nmi ? 0 : 1);
        chk("R8 R5 R1 new pc", new_pc, tbl({6'd0, ev, 2'b00}));
        chk("R8 new cs", new_cs, tbl({6'd0, ev, 2'b10}));
        chk("R7 ie cleared", ie_flag, 0);
        chk("R7 tf cleared", tf_flag, 0);
        chk("R11 busy low after", busy, 0);
        chk("R10 R11 busy length", busy_cnt - b0,
            (nmi ? 0 : 1) + (1 + lt) + 4 * (2 + lt));
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int b0, d0, w0;
        logic [7:0] vs [7];
        vs = '{8'd0, 8'd1, 8'd5, 8'd8, 8'd127, 8'd200, 8'd255};
        repeat (3) tick();
        rst_n = 1;
        tick();
        chk("R11 reset busy", busy, 0);
        chk("R3 reset ie", ie_flag, 0);
        chk("R3 reset tf", tf_flag, 0);
        chk("R5 reset ack", int_ack, 0);
        chk("R10 reset valid", mem_valid, 0);

        // R3 both commands: clear wins
        ie_set = 1; tick(); ie_set = 0; tick();
        chk("R3 set", ie_flag, 1);
        ie_set = 1; ie_clr = 1; tick(); ie_set = 0; ie_clr = 0; tick();
        chk("R3 clear wins", ie_flag, 0);

        // R2 masked request stays pending
        b0 = busy_cnt;
        irq_req = 1;
        for (int k = 0; k < 3; k++) begin
            insn_end = 1; tick(); insn_end = 0; tick();
        end
        chk("R2 masked not taken", busy_cnt - b0, 0);
        entry(1'b0, 1'b1, 8'd9, 0, 1'b1, 1'b0, 16'h8300);

        // R4 no boundary, no entry
        ie_set = 1; tick(); ie_set = 0;
        b0 = busy_cnt; irq_req = 1;
        repeat (6) tick();
        chk("R4 no boundary no entry", busy_cnt - b0, 0);
        irq_req = 0;

        // main sweep of maskable entries
        for (int v = 0; v < 7; v++)
            for (int l = 0; l < 3; l++)
                entry(1'b0, 1'b1, vs[v], l, 1'b1, (v + l) % 2 == 1,
                      16'h8300 - 16'(16 * (v * 3 + l)));

        // R1 non-maskable with enable clear, R9 both together
        for (int l = 0; l < 3; l++) begin
            entry(1'b1, 1'b0, 8'd77, l, 1'b0, l == 1, 16'h8200);
            entry(1'b1, 1'b1, 8'd44, l, 1'b1, 1'b0, 16'h8180);
        end

        // R11 requests during busy are ignored
        lat = 2; vec_in = 8'd3; sp_in = 16'h8100;
        ie_set = 1; tick(); ie_set = 0;
        d0 = done_cnt; w0 = wr_cnt;
        irq_req = 1; insn_end = 1; tick();
        irq_req = 0; insn_end = 0;
        repeat (3) tick();
        nmi_req = 1; insn_end = 1; tick(); tick();
        nmi_req = 0; insn_end = 0;
        wait_done(d0);
        repeat (40) tick();
        chk("R11 one entry only", done_cnt - d0, 1);
        chk("R11 three writes only", wr_cnt - w0, 3);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule